// File: doc/BRIEF.md
# Block Transfer DMA Sequencer

This engine moves a block of bytes between the host memory bus and an expansion RAM once the host has set up the execute flag, the transfer kind, the start addresses, the byte count and the address stepping mode. It halts the host processor while it owns the bus. It then handles one byte per step in one of four ways: store (host to expansion), fetch (expansion to host), swap (exchange through a pair of holding bytes) or verify (compare; a mismatch stops the run). Each address counter either steps by one per byte or stays fixed. A down counter tracks the bytes that remain.

The start can be deferred until the host writes to address $FF00. While the bus-available input is low, the engine drives nothing and its counters stay frozen. When the run ends it raises a one-cycle end-of-block pulse, and also a fault pulse if a verify failed. It then lets the processor run again. If autoload is set, it also reloads its counters with the programmed values. Register decode and the expansion RAM are outside the engine. Read data comes back combinationally in the cycle the address is presented, and writes take effect at the clock edge.

Top module: `blkx_engine`

## Requirements
- R1: With `exec` high and the engine idle, it pulses `exec_clr` for exactly one cycle and starts one transfer. It does not start again until a later `exec`.
- R2: With `nowait` low, the engine keeps `halt_n` high and performs no bus access until `snoop_we` is seen with `snoop_addr` equal to 16'hFF00. A write to any other address is ignored. The detector is cleared once it fires.
- R3: `kind` 2'b00 copies each host byte to the expansion RAM and `kind` 2'b01 copies each expansion byte to the host. Each byte takes one bus cycle.
- R4: `kind` 2'b10 exchanges the host byte and the expansion byte. It takes two bus cycles per byte: a read cycle, then a write cycle on both buses.
- R5: `kind` 2'b11 compares the bytes without writing anything. On the first mismatch, the run ends with `fault_set` and `eob_set` together, and the counters are left pointing at the mismatching byte. The mismatching cycle counts as a bus cycle.
- R6: In `hold`, bit 0 set freezes the expansion address and bit 1 set freezes the host address. Any address not frozen steps by one per completed byte.
- R7: A `len_cfg` of 0 means 65536 bytes. The expansion address wraps from 19'h7FFFF to 0 and the host address wraps from 16'hFFFF to 0.
- R8: With `autoload` set, `cur_host`, `cur_exp` and `cur_rem` return to the programmed start values after the run. Without it, they keep their final values, and `cur_rem` ends at 0 on a complete run.
- R9: While `ba` is low, the engine drives `h_drv`, `h_we` and `x_we` low and holds its counters.
- R10: `halt_n` is low only during bus cycles of a run. After the last byte, `eob_set` pulses for one cycle with `halt_n` already high. After reset the engine is idle with every strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Execute flag from the register file |
| exec_clr | output | 1 | One-cycle pulse that clears the execute flag |
| autoload | input | 1 | Reload counters with programmed values at end |
| nowait | input | 1 | 1: start at once; 0: wait for a write to $FF00 |
| kind | input | 2 | Transfer kind: 00 store, 01 fetch, 10 swap, 11 verify |
| hold | input | 2 | Bit 0 freezes the expansion address, bit 1 freezes the host address |
| host_base | input | 16 | Programmed host start address |
| exp_base | input | 19 | Programmed expansion start address |
| len_cfg | input | 16 | Programmed byte count (0 means 65536) |
| ba | input | 1 | Bus available; low stalls the engine |
| halt_n | output | 1 | Low while the host processor must stay halted |
| snoop_we | input | 1 | Host write strobe, watched for the deferred start |
| snoop_addr | input | 16 | Host write address, watched for the deferred start |
| h_drv | output | 1 | Host bus drivers enabled |
| h_addr | output | 16 | Host bus address |
| h_wdata | output | 8 | Host bus write data |
| h_rdata | input | 8 | Host bus read data |
| h_we | output | 1 | Host bus write strobe |
| x_addr | output | 19 | Expansion RAM address |
| x_wdata | output | 8 | Expansion RAM write data |
| x_rdata | input | 8 | Expansion RAM read data |
| x_we | output | 1 | Expansion RAM write strobe |
| eob_set | output | 1 | End-of-block pulse |
| fault_set | output | 1 | Verify-mismatch pulse |
| cur_host | output | 16 | Live host address counter |
| cur_exp | output | 19 | Live expansion address counter |
| cur_rem | output | 17 | Bytes remaining |

## Verification
The hardest case to reach is a swap stalled between its read cycle and its write cycle. There, only the holding bytes carry the data across the gap. A bus-available line that drops at random in about a quarter of cycles, combined with many short swaps, lands stalls in that window often. A verify mismatch at a chosen byte is produced by changing one expansion byte in both the bench memory and its reference copy after a store. The 65536-byte run starts a few bytes below the top of both address spaces, so both counters wrap during the run.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    XK_STORE  = 2'b00,
    XK_FETCH  = 2'b01,
    XK_SWAP   = 2'b10,
    XK_VERIFY = 2'b11
  } xkind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_MOVE,
    ST_SWPW,
    ST_FIN
  } xstate_e;
endpackage

// File: rtl/blkx_trigger.sv
module blkx_trigger #(
  parameter int AW = 16,
  parameter logic [AW-1:0] MATCH = 16'hFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          clr,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  output logic          hit
);
  logic hit_q, hit_d;

  always_comb begin
    hit_d = hit_q;
    if (clr)
      hit_d = 1'b0;
    else if (arm && wr_stb && (wr_addr == MATCH))
      hit_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign hit = hit_q;

  // R2
  hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(wr_stb && (wr_addr == MATCH)));
endmodule

// File: rtl/blkx_addr_ctr.sv
module blkx_addr_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         hold,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (load)
      q_d = load_val;
    else if (step && !hold)
      q_d = q_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> (q == $past(q)));
  // R7
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold && !load && (q == {W{1'b1}})) |=> (q == '0));
endmodule

// File: rtl/blkx_ctrl.sv
module blkx_ctrl
  import blkx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   exec,
  input  logic   nowait,
  input  logic   autoload,
  input  xkind_e kind,
  input  logic   ba,
  input  logic   hit,
  input  logic   same,
  input  logic   last,
  output logic   exec_clr,
  output logic   arm,
  output logic   trig_clr,
  output logic   ld,
  output logic   step,
  output logic   cap,
  output logic   we_h,
  output logic   we_x,
  output logic   drive,
  output logic   halt_n,
  output logic   eob_set,
  output logic   fault_set
);
  xstate_e st_q, st_d;
  logic    fault_q, fault_d;

  always_comb begin
    st_d      = st_q;
    fault_d   = fault_q;
    exec_clr  = 1'b0;
    arm       = 1'b0;
    trig_clr  = 1'b0;
    ld        = 1'b0;
    step      = 1'b0;
    cap       = 1'b0;
    we_h      = 1'b0;
    we_x      = 1'b0;
    drive     = 1'b0;
    halt_n    = 1'b1;
    eob_set   = 1'b0;
    fault_set = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (exec) begin
          exec_clr = 1'b1;
          ld       = 1'b1;
          fault_d  = 1'b0;
          st_d     = nowait ? ST_MOVE : ST_ARM;
        end
      end
      ST_ARM: begin
        arm = 1'b1;
        if (hit) begin
          trig_clr = 1'b1;
          st_d     = ST_MOVE;
        end
      end
      ST_MOVE: begin
        halt_n = 1'b0;
        if (ba) begin
          drive = 1'b1;
          unique case (kind)
            XK_STORE: begin
              we_x = 1'b1;
              step = 1'b1;
              if (last) st_d = ST_FIN;
            end
            XK_FETCH: begin
              we_h = 1'b1;
              step = 1'b1;
              if (last) st_d = ST_FIN;
            end
            XK_SWAP: begin
              cap  = 1'b1;
              st_d = ST_SWPW;
            end
            XK_VERIFY: begin
              if (same) begin
                step = 1'b1;
                if (last) st_d = ST_FIN;
              end else begin
                fault_d = 1'b1;
                st_d    = ST_FIN;
              end
            end
          endcase
        end
      end
      ST_SWPW: begin
        halt_n = 1'b0;
        if (ba) begin
          drive = 1'b1;
          we_h  = 1'b1;
          we_x  = 1'b1;
          step  = 1'b1;
          st_d  = last ? ST_FIN : ST_MOVE;
        end
      end
      ST_FIN: begin
        eob_set   = 1'b1;
        fault_set = fault_q;
        ld        = autoload;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= fault_d;
    end
  end

  // R1
  exec_clr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_clr |=> (!exec_clr && (!halt_n || arm)));
  // R2
  arm_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (halt_n && !drive));
  // R9
  ba_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ba |-> (!we_h && !we_x && !drive));
  // R10
  eob_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eob_set |-> (halt_n && $past(!halt_n)));
  // R5
  fault_with_eob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |-> eob_set);
endmodule

// File: rtl/blkx_engine.sv
module blkx_engine
  import blkx_pkg::*;
#(
  parameter int HAW = 16,
  parameter int XAW = 19,
  parameter int DW  = 8,
  parameter int LW  = 16,
  parameter logic [HAW-1:0] TRIG_ADDR = 16'hFF00
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec,
  output logic           exec_clr,
  input  logic           autoload,
  input  logic           nowait,
  input  logic [1:0]     kind,
  input  logic [1:0]     hold,
  input  logic [HAW-1:0] host_base,
  input  logic [XAW-1:0] exp_base,
  input  logic [LW-1:0]  len_cfg,
  input  logic           ba,
  output logic           halt_n,
  input  logic           snoop_we,
  input  logic [HAW-1:0] snoop_addr,
  output logic           h_drv,
  output logic [HAW-1:0] h_addr,
  output logic [DW-1:0]  h_wdata,
  input  logic [DW-1:0]  h_rdata,
  output logic           h_we,
  output logic [XAW-1:0] x_addr,
  output logic [DW-1:0]  x_wdata,
  input  logic [DW-1:0]  x_rdata,
  output logic           x_we,
  output logic           eob_set,
  output logic           fault_set,
  output logic [HAW-1:0] cur_host,
  output logic [XAW-1:0] cur_exp,
  output logic [LW:0]    cur_rem
);
  localparam int RW = LW + 1;
  localparam logic [RW-1:0] FULL_LEN = {1'b1, {LW{1'b0}}};

  // reset: asserted at once, released after two clean edges
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  xkind_e kind_e;
  assign kind_e = xkind_e'(kind);

  logic hit, arm, trig_clr, ld, step, cap, same, last;

  blkx_trigger #(.AW(HAW), .MATCH(TRIG_ADDR)) u_trig (
    .clk(clk), .rst_n(rst_s), .arm(arm), .clr(trig_clr),
    .wr_stb(snoop_we), .wr_addr(snoop_addr), .hit(hit)
  );

  blkx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s), .exec(exec), .nowait(nowait),
    .autoload(autoload), .kind(kind_e), .ba(ba), .hit(hit),
    .same(same), .last(last), .exec_clr(exec_clr), .arm(arm),
    .trig_clr(trig_clr), .ld(ld), .step(step), .cap(cap),
    .we_h(h_we), .we_x(x_we), .drive(h_drv), .halt_n(halt_n),
    .eob_set(eob_set), .fault_set(fault_set)
  );

  blkx_addr_ctr #(.W(HAW)) u_hctr (
    .clk(clk), .rst_n(rst_s), .load(ld), .load_val(host_base),
    .step(step), .hold(hold[1]), .q(cur_host)
  );

  blkx_addr_ctr #(.W(XAW)) u_xctr (
    .clk(clk), .rst_n(rst_s), .load(ld), .load_val(exp_base),
    .step(step), .hold(hold[0]), .q(cur_exp)
  );

  // remaining-byte counter
  logic [RW-1:0] rem_q, rem_d, rem_init;
  assign rem_init = (len_cfg == '0) ? FULL_LEN : {1'b0, len_cfg};

  always_comb begin
    rem_d = rem_q;
    if (ld)
      rem_d = rem_init;
    else if (step)
      rem_d = rem_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign last    = (rem_q == RW'(1));
  assign cur_rem = rem_q;

  // swap holding bytes
  logic [DW-1:0] keep_h_q, keep_x_q, keep_h_d, keep_x_d;
  always_comb begin
    keep_h_d = keep_h_q;
    keep_x_d = keep_x_q;
    if (cap) begin
      keep_h_d = h_rdata;
      keep_x_d = x_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      keep_h_q <= '0;
      keep_x_q <= '0;
    end else begin
      keep_h_q <= keep_h_d;
      keep_x_q <= keep_x_d;
    end
  end

  assign same    = (h_rdata == x_rdata);
  assign h_addr  = cur_host;
  assign x_addr  = cur_exp;
  assign h_wdata = (kind_e == XK_SWAP) ? keep_x_q : x_rdata;
  assign x_wdata = (kind_e == XK_SWAP) ? keep_h_q : h_rdata;

  // R7
  rem_live_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !halt_n |-> (cur_rem != '0));
  // R9
  ba_freeze_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!ba && !halt_n) |=> (cur_rem == $past(cur_rem)));
  // R5
  verify_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (kind_e == XK_VERIFY) |-> (!h_we && !x_we));
endmodule

// File: tb/tb_blkx_engine.sv
module tb_blkx_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, exec, exec_clr, autoload, nowait, ba, halt_n;
  logic [1:0]  kind, hold;
  logic [15:0] host_base, len_cfg, snoop_addr, h_addr, cur_host;
  logic [18:0] exp_base, x_addr, cur_exp;
  logic        snoop_we, h_drv, h_we, x_we, eob_set, fault_set;
  logic [7:0]  h_wdata, h_rdata, x_wdata, x_rdata;
  logic [16:0] cur_rem;

  blkx_engine dut (
    .clk(clk), .rst_n(rst_n), .exec(exec), .exec_clr(exec_clr),
    .autoload(autoload), .nowait(nowait), .kind(kind), .hold(hold),
    .host_base(host_base), .exp_base(exp_base), .len_cfg(len_cfg),
    .ba(ba), .halt_n(halt_n), .snoop_we(snoop_we), .snoop_addr(snoop_addr),
    .h_drv(h_drv), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .h_we(h_we), .x_addr(x_addr), .x_wdata(x_wdata), .x_rdata(x_rdata),
    .x_we(x_we), .eob_set(eob_set), .fault_set(fault_set),
    .cur_host(cur_host), .cur_exp(cur_exp), .cur_rem(cur_rem)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] dh [int unsigned];
  logic [7:0] dx [int unsigned];
  logic [7:0] rh [int unsigned];
  logic [7:0] rx [int unsigned];

  function automatic logic [7:0] hinit(int unsigned a);
    return 8'((a * 29 + 90) ^ (a >> 8));
  endfunction
  function automatic logic [7:0] xinit(int unsigned a);
    return 8'((a * 53 + 17) ^ (a >> 11) ^ (a >> 3));
  endfunction
  function automatic logic [7:0] rd_dh(int unsigned a);
    return dh.exists(a) ? dh[a] : hinit(a);
  endfunction
  function automatic logic [7:0] rd_dx(int unsigned a);
    return dx.exists(a) ? dx[a] : xinit(a);
  endfunction
  function automatic logic [7:0] rd_rh(int unsigned a);
    return rh.exists(a) ? rh[a] : hinit(a);
  endfunction
  function automatic logic [7:0] rd_rx(int unsigned a);
    return rx.exists(a) ? rx[a] : xinit(a);
  endfunction

  int gen = 0;
  always @(h_addr or x_addr or gen) begin
    h_rdata = rd_dh(32'(h_addr));
    x_rdata = rd_dx(32'(x_addr));
  end

  int busy = 0, nclr = 0, viol_ba = 0, viol_wait = 0;
  bit stall = 1'b0, waiting = 1'b0;

  always @(posedge clk) begin
    if (h_we) begin dh[32'(h_addr)] = h_wdata; gen++; end
    if (x_we) begin dx[32'(x_addr)] = x_wdata; gen++; end
    if (!halt_n && ba) busy++;
    if (!ba && (h_we || x_we || h_drv)) viol_ba++;
    if (waiting && (!halt_n || h_drv)) viol_wait++;
    if (exec_clr) begin nclr++; exec <= 1'b0; end
  end

  always @(negedge clk) ba <= stall ? ($urandom_range(0, 3) != 0) : 1'b1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  function automatic int mem_diff();
    int bad = 0;
    foreach (rh[k]) if (rd_dh(k) != rh[k]) bad++;
    foreach (dh[k]) if (rd_rh(k) != dh[k]) bad++;
    foreach (rx[k]) if (rd_dx(k) != rx[k]) bad++;
    foreach (dx[k]) if (rd_rx(k) != dx[k]) bad++;
    return bad;
  endfunction

  task automatic do_xfer(int k, int unsigned ha, int unsigned xa, int unsigned lc,
                         int hd, bit al, bit nw, bit st);
    int unsigned nfull, s, hh, xx, e_h, e_x, e_r, e_busy, tmo;
    bit flt;
    logic [7:0] t;
    string rq;
    bit seen_fault, halt_at_eob;
    nfull = (lc == 0) ? 65536 : lc;
    s = 0; flt = 1'b0;
    for (int i = 0; i < int'(nfull); i++) begin
      hh = (ha + (hd[1] ? 0 : i)) & 32'hFFFF;
      xx = (xa + (hd[0] ? 0 : i)) & 32'h7FFFF;
      case (k)
        0: rx[xx] = rd_rh(hh);
        1: rh[hh] = rd_rx(xx);
        2: begin t = rd_rh(hh); rh[hh] = rd_rx(xx); rx[xx] = t; end
        default: if (rd_rh(hh) != rd_rx(xx)) begin flt = 1'b1; break; end
      endcase
      s++;
    end
    e_busy = (k == 2) ? 2 * s : (flt ? s + 1 : s);
    if (al) begin
      e_h = ha; e_x = xa; e_r = nfull;
    end else begin
      e_h = (ha + (hd[1] ? 0 : s)) & 32'hFFFF;
      e_x = (xa + (hd[0] ? 0 : s)) & 32'h7FFFF;
      e_r = nfull - s;
    end
    rq = (lc == 0) ? "R7" : (k < 2) ? "R3" : (k == 2) ? "R4" : "R5";

    @(negedge clk);
    kind = 2'(k); hold = 2'(hd); host_base = 16'(ha); exp_base = 19'(xa);
    len_cfg = 16'(lc); autoload = al; nowait = nw;
    busy = 0; nclr = 0; viol_ba = 0; viol_wait = 0;
    stall = st; exec = 1'b1;
    if (!nw) begin
      waiting = 1'b1;
      repeat (6) @(negedge clk);
      snoop_we = 1'b1; snoop_addr = 16'hFF01;
      @(negedge clk);
      snoop_we = 1'b0;
      repeat (4) @(negedge clk);
      waiting = 1'b0;
      snoop_we = 1'b1; snoop_addr = 16'hFF00;
      @(negedge clk);
      snoop_we = 1'b0;
    end
    tmo = 3 * nfull + 100; seen_fault = 1'b0; halt_at_eob = 1'b0;
    forever begin
      @(negedge clk);
      if (eob_set) begin seen_fault = fault_set; halt_at_eob = halt_n; break; end
      if (tmo == 0) break;
      tmo--;
    end
    stall = 1'b0;
    @(negedge clk);
    chk(tmo != 0, "R10", "end of block seen", tmo, 1);
    chk(halt_at_eob, "R10", "halt released at eob", halt_at_eob, 1);
    chk(mem_diff() == 0, rq, "memory contents", mem_diff(), 0);
    chk(busy == e_busy, rq, "bus cycles", busy, e_busy);
    chk(seen_fault == flt, "R5", "fault pulse", seen_fault, flt);
    chk(cur_host == 16'(e_h), al ? "R8" : "R6", "host counter", cur_host, e_h);
    chk(cur_exp == 19'(e_x), al ? "R8" : "R6", "expansion counter", cur_exp, e_x);
    chk(cur_rem == 17'(e_r), "R8", "remaining count", cur_rem, e_r);
    chk(nclr == 1, "R1", "execute clear pulses", nclr, 1);
    chk(viol_ba == 0, "R9", "activity with ba low", viol_ba, 0);
    if (!nw) chk(viol_wait == 0, "R2", "activity before trigger", viol_wait, 0);
    repeat (3) @(negedge clk);
    chk(halt_n && !h_drv, "R1", "no restart", {halt_n, h_drv}, 2);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; exec = 1'b0; autoload = 1'b0; nowait = 1'b1; kind = 2'b00;
    hold = 2'b00; host_base = '0; exp_base = '0; len_cfg = 16'd1;
    snoop_we = 1'b0; snoop_addr = '0; ba = 1'b1;
    repeat (3) @(negedge clk);
    chk(halt_n && !h_drv && !h_we && !x_we && !eob_set && !exec_clr, "R10",
        "reset state", {halt_n, h_drv, h_we, x_we, eob_set, exec_clr}, 6'b100000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    do_xfer(0, 32'h1000, 32'h00100, 16, 0, 0, 1, 0);   // R3 store
    do_xfer(1, 32'h2000, 32'h00100, 16, 0, 1, 1, 0);   // R3 fetch, R8 autoload
    do_xfer(2, 32'h3000, 32'h04000, 8, 0, 0, 1, 1);    // R4 swap under stalls, R9
    do_xfer(3, 32'h1000, 32'h00100, 16, 0, 0, 1, 1);   // R5 matching verify
    v = ~rd_rx(32'h105);
    rx[32'h105] = v; dx[32'h105] = v;
    do_xfer(3, 32'h1000, 32'h00100, 16, 0, 0, 1, 0);   // R5 mismatch at byte 5
    do_xfer(0, 32'h5000, 32'h10000, 5, 1, 0, 1, 0);    // R6 expansion frozen
    do_xfer(1, 32'h6000, 32'h11000, 5, 2, 0, 1, 0);    // R6 host frozen
    do_xfer(2, 32'h7000, 32'h12000, 3, 3, 0, 1, 1);    // R6 both frozen
    do_xfer(0, 32'h8000, 32'h13000, 6, 0, 1, 0, 0);    // R2 deferred start
    do_xfer(0, 32'hFFF0, 32'h7FFF8, 0, 0, 0, 1, 0);    // R7 full 64K, wraps

    for (int i = 0; i < 20; i++) begin
      do_xfer($urandom_range(0, 3), $urandom_range(0, 65535),
              $urandom_range(0, 32'h7FFFF), $urandom_range(1, 40),
              $urandom_range(0, 3), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)));
    end

    summary();
    $finish;
  end
endmodule